// File: doc/BRIEF.md
# Serial SAR ADC Readout Controller

This block runs single conversions on an external 10-bit successive-approximation converter that has a three-wire serial port (chip select, serial clock, data out). It sits on the host side. When a start request is accepted, the block pulls chip select low. It then watches the data line until the converter raises it high to mark the end of the conversion. After that it clocks out the result and presents it on a parallel bus with a one-cycle valid pulse. If the marker never comes, the block gives up after a set bound, releases chip select and pulses a timeout flag instead.

The serial clock is derived from the system clock, idles low and runs only while a result is being read. The converter updates its data output on the falling edge of the serial clock, so the block samples on the rising edge, after a small synchronizer. The first rising edge captures the end-of-conversion bit and discards it. The next ten rising edges capture the result, most significant bit first, in straight binary. Between frames the block keeps chip select high long enough for the converter's minimum deselect time and for its track/hold acquisition.

The block also drives the converter's active-low shutdown pin from a sleep request. No conversion starts while shutdown is driven. Every timing quantity is a parameter in system-clock cycles. Elaboration stops with an error if a parameter breaks the converter's limits:
- each serial-clock phase must last at least 200 ns;
- the serial clock must run at 2.1 MHz or slower;
- chip select must stay high for at least 240 ns;
- acquisition must last at least 1.5 µs;
- the timeout must be longer than the 7.5 µs conversion time.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `cs_n_o` is 1, `sclk_o` is 0, `valid_o` and `timeout_o` are 0 and `result_o` is 0. After reset, `busy_o` stays 1 until the inter-frame gap has elapsed.
- R2: A start request is taken only when `start_i` is 1, `busy_o` is 0 and `shdn_n_o` is 1. When it is taken, `cs_n_o` falls at the next clock edge. A start request made while `busy_o` is 1 is ignored: no extra frame follows it.
- R3: `sclk_o` is 0 whenever `cs_n_o` is 1. No rising edge of `sclk_o` occurs before the end-of-conversion bit (`sdata_i` = 1) has been seen.
- R4: Once end of conversion is seen, exactly RES_BITS+1 = 11 rising edges of `sclk_o` occur before `cs_n_o` rises. Every high phase and every low phase of `sclk_o` lasts at least HALF_CYC cycles.
- R5: The bit sampled at the first rising edge is the end-of-conversion bit and is discarded. The bits sampled at the following 10 rising edges form `result_o`, most significant bit first, with bit 9 the first of them, in straight binary.
- R6: `valid_o` is a single-cycle pulse in the cycle in which `cs_n_o` returns high after a complete read. `result_o` changes only in that cycle and holds its value until the next valid pulse.
- R7: If `sdata_i` has not gone high within TIMEOUT_CYC cycles, counted from the cycle in which `cs_n_o` falls, then `cs_n_o` returns high after exactly TIMEOUT_CYC cycles low. `timeout_o` pulses for one cycle, no `sclk_o` edge occurs, `valid_o` stays 0 and `result_o` is unchanged.
- R8: Between the rise of `cs_n_o` and its next fall, and between reset and the first fall, `cs_n_o` stays high for at least max(CSH_CYC, ACQ_CYC) cycles.
- R9: `shdn_n_o` equals the inverse of `sleep_i`, delayed by one clock. While `shdn_n_o` is 0, `cs_n_o` does not fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to run one conversion |
| sleep_i | input | 1 | Request to power the converter down |
| busy_o | output | 1 | A frame or the inter-frame gap is in progress; start requests are ignored |
| cs_n_o | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Serial clock to the converter, idles low |
| sdata_i | input | 1 | Serial data from the converter |
| shdn_n_o | output | 1 | Converter shutdown control, active low |
| result_o | output | RES_BITS | Last conversion result, straight binary |
| valid_o | output | 1 | One-cycle pulse when `result_o` is updated |
| timeout_o | output | 1 | One-cycle pulse when no end of conversion was seen |

## Verification
The converter model in the bench returns directed codes and random codes, each after a random conversion delay:
- All-zeros and all-ones show a stuck or missing bit.
- The two alternating patterns and the single-MSB code show a swapped bit order, or a frame that is off by one bit when the marker bit is kept or dropped.
- A very short conversion delay and one just under the timeout separate polling before clocking from clocking at once, and separate a correct timeout bound from one that is too short.
- A converter that never raises the marker must produce the timeout path with an exact low time and an unchanged result.
- Start requests made mid-frame and under sleep must produce no extra chip-select fall.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SHIFT = 2'd2
  } rd_state_t;

  // Chip select must cover both the deselect time and the acquisition time.
  function automatic int gap_cycles(input int csh, input int acq);
    return (csh > acq) ? csh : acq;
  endfunction

  // One marker bit followed by the data bits.
  function automatic int frame_edges(input int res);
    return res + 1;
  endfunction

endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] r;

  always_ff @(posedge clk) begin
    if (rst) begin
      r <= '0;
    end else begin
      r[0] <= d;
      for (int i = 1; i < STAGES; i++) r[i] <= r[i-1];
    end
  end

  assign q = r[STAGES-1];
endmodule

// File: rtl/adc_rd_sclk_gen.sv
module adc_rd_sclk_gen #(
  parameter int HALF_CYC = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic sclk,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = $clog2(HALF_CYC);

  logic [CW-1:0] cnt;
  logic          ph;
  logic          tick;

  assign tick     = en && (cnt == CW'(HALF_CYC - 1));
  assign rise_evt = tick && !ph;
  assign fall_evt = tick && ph;
  assign sclk     = ph;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      ph  <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      ph  <= ~ph;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
  parameter int BITS = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            shift_en,
  input  logic            din,
  output logic [BITS-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst || clr) word <= '0;
    else if (shift_en) word <= {word[BITS-2:0], din};
  end
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int CLK_NS      = 4,
  parameter int HALF_CYC    = 60,
  parameter int CSH_CYC     = 60,
  parameter int ACQ_CYC     = 375,
  parameter int TIMEOUT_CYC = 2000,
  parameter int SYNC_STAGES = 2,
  parameter int RES_BITS    = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                sleep_i,
  output logic                busy_o,
  output logic                cs_n_o,
  output logic                sclk_o,
  input  logic                sdata_i,
  output logic                shdn_n_o,
  output logic [RES_BITS-1:0] result_o,
  output logic                valid_o,
  output logic                timeout_o
);
  localparam int GAP_CYC = gap_cycles(CSH_CYC, ACQ_CYC);
  localparam int GAP_W   = $clog2(GAP_CYC + 1);
  localparam int TMO_W   = $clog2(TIMEOUT_CYC);
  localparam int EDGES   = frame_edges(RES_BITS);
  localparam int EDGE_W  = $clog2(EDGES + 1);
  localparam int PIPE    = SYNC_STAGES + 1;

  // Parameter limits against the converter timing.
  if (HALF_CYC * CLK_NS < 200) begin : g_bad_phase
    $error("serial clock phase shorter than 200 ns");
  end
  if (2 * HALF_CYC * CLK_NS * 21 < 10000) begin : g_bad_rate
    $error("serial clock faster than 2.1 MHz");
  end
  if (CSH_CYC * CLK_NS < 240) begin : g_bad_csh
    $error("chip select high time below 240 ns");
  end
  if (ACQ_CYC * CLK_NS < 1500) begin : g_bad_acq
    $error("acquisition time below 1.5 us");
  end
  if (TIMEOUT_CYC * CLK_NS <= 7500) begin : g_bad_tmo
    $error("timeout not above the 7.5 us conversion time");
  end
  if (HALF_CYC <= PIPE + 1) begin : g_bad_sync
    $error("serial clock phase too short for the synchronizer");
  end

  rd_state_t           state;
  logic [TMO_W-1:0]    wcnt;
  logic [GAP_W-1:0]    gcnt;
  logic [EDGE_W-1:0]   edge_cnt;
  logic [PIPE-1:0]     samp_pipe;
  logic                shdn_q;
  logic [RES_BITS-1:0] word;

  // Named internal events.
  logic sd_sync;
  logic rise_evt, fall_evt;
  logic gap_done, start_accept, eoc_seen, tmo_hit, frame_done, samp_stb;

  adc_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(sdata_i), .q(sd_sync)
  );

  adc_rd_sclk_gen #(.HALF_CYC(HALF_CYC)) u_sclk (
    .clk(clk), .rst(rst), .en(state == ST_SHIFT),
    .sclk(sclk_o), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  assign gap_done     = (gcnt == GAP_W'(GAP_CYC));
  assign start_accept = (state == ST_IDLE) && gap_done && shdn_q && start_i;
  assign eoc_seen     = (state == ST_WAIT) && sd_sync;
  assign tmo_hit      = (state == ST_WAIT) && !sd_sync && (wcnt == TMO_W'(TIMEOUT_CYC - 1));
  assign frame_done   = (state == ST_SHIFT) && fall_evt && (edge_cnt == EDGE_W'(EDGES - 1));
  assign samp_stb     = samp_pipe[PIPE-1];

  adc_rd_capture #(.BITS(RES_BITS)) u_cap (
    .clk(clk), .rst(rst), .clr(start_accept), .shift_en(samp_stb),
    .din(sd_sync), .word(word)
  );

  // Delay the rising-edge event by the synchronizer latency before sampling.
  always_ff @(posedge clk) begin
    if (rst) samp_pipe <= '0;
    else     samp_pipe <= {samp_pipe[PIPE-2:0], rise_evt};
  end

  always_ff @(posedge clk) begin
    if (rst) shdn_q <= 1'b1;
    else     shdn_q <= ~sleep_i;
  end
  assign shdn_n_o = shdn_q;

  // Cycles since chip select went high, saturating at the gap.
  always_ff @(posedge clk) begin
    if (rst || !cs_n_o)  gcnt <= '0;
    else if (!gap_done)  gcnt <= gcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cs_n_o    <= 1'b1;
      wcnt      <= '0;
      edge_cnt  <= '0;
      result_o  <= '0;
      valid_o   <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      valid_o   <= 1'b0;
      timeout_o <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_accept) begin
            state    <= ST_WAIT;
            cs_n_o   <= 1'b0;
            wcnt     <= '0;
            edge_cnt <= '0;
          end
        end
        ST_WAIT: begin
          if (eoc_seen) begin
            state <= ST_SHIFT;
          end else if (tmo_hit) begin
            state     <= ST_IDLE;
            cs_n_o    <= 1'b1;
            timeout_o <= 1'b1;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (fall_evt) edge_cnt <= edge_cnt + 1'b1;
          if (frame_done) begin
            state    <= ST_IDLE;
            cs_n_o   <= 1'b1;
            result_o <= word;
            valid_o  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state != ST_IDLE) || !gap_done;

endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk
  import adc_rd_pkg::*;
#(
  parameter int HALF_CYC = 60,
  parameter int CSH_CYC  = 60,
  parameter int ACQ_CYC  = 375,
  parameter int RES_BITS = 10
) (
  input logic                clk,
  input logic                rst,
  input logic                start_i,
  input logic                busy_o,
  input logic                cs_n_o,
  input logic                sclk_o,
  input logic                shdn_n_o,
  input logic [RES_BITS-1:0] result_o,
  input logic                valid_o,
  input logic                timeout_o
);
  localparam int GAP   = gap_cycles(CSH_CYC, ACQ_CYC);
  localparam int HW    = $clog2(GAP + 1) + 1;
  localparam int PW    = $clog2(HALF_CYC + 1) + 1;
  localparam int RW    = $clog2(RES_BITS + 3);

  logic [HW-1:0] hi_cnt;
  logic [PW-1:0] ph_cnt;
  logic [RW-1:0] rise_cnt;
  logic          sclk_q, cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt   <= '0;
      ph_cnt   <= PW'(HALF_CYC);
      rise_cnt <= '0;
      sclk_q   <= 1'b0;
      cs_q     <= 1'b1;
    end else begin
      sclk_q <= sclk_o;
      cs_q   <= cs_n_o;
      if (!cs_n_o) hi_cnt <= '0;
      else if (hi_cnt < HW'(GAP)) hi_cnt <= hi_cnt + 1'b1;
      if (sclk_o != sclk_q) ph_cnt <= PW'(1);
      else if (ph_cnt < PW'(HALF_CYC)) ph_cnt <= ph_cnt + 1'b1;
      if (cs_q && !cs_n_o) rise_cnt <= '0;
      else if (sclk_o && !sclk_q) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  AST_RST_IDLE: assert property (@(posedge clk)
    rst |=> (cs_n_o && !sclk_o && !valid_o && !timeout_o)); // R1

  AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> $past(start_i && !busy_o && shdn_n_o)); // R2

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sclk_o); // R3

  AST_SCLK_PHASE: assert property (@(posedge clk) disable iff (rst)
    (sclk_o != sclk_q) |-> (ph_cnt >= PW'(HALF_CYC))); // R4

  AST_EDGE_COUNT: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_o) |-> ((rise_cnt == RW'(RES_BITS + 1) && valid_o) ||
                       (rise_cnt == '0 && timeout_o))); // R7

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o); // R6

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(result_o)); // R6

  AST_CS_GAP: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> (hi_cnt >= HW'(GAP))); // R8

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!shdn_n_o && cs_n_o) |=> cs_n_o); // R9

endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(
  .HALF_CYC(HALF_CYC), .CSH_CYC(CSH_CYC), .ACQ_CYC(ACQ_CYC), .RES_BITS(RES_BITS)
) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o), .cs_n_o(cs_n_o),
  .sclk_o(sclk_o), .shdn_n_o(shdn_n_o), .result_o(result_o),
  .valid_o(valid_o), .timeout_o(timeout_o)
);

// File: tb/tb_adc_rd_ctrl.sv
module tb_adc_rd_ctrl;
  localparam int HALF = 60;
  localparam int CSH  = 60;
  localparam int ACQ  = 375;
  localparam int TMO  = 2000;
  localparam int RES  = 10;

  logic clk = 1'b0;
  logic rst, start_i, sleep_i, sdata_i;
  logic busy_o, cs_n_o, sclk_o, shdn_n_o, valid_o, timeout_o;
  logic [RES-1:0] result_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  adc_rd_ctrl #(
    .CLK_NS(4), .HALF_CYC(HALF), .CSH_CYC(CSH), .ACQ_CYC(ACQ),
    .TIMEOUT_CYC(TMO), .SYNC_STAGES(2), .RES_BITS(RES)
  ) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .sleep_i(sleep_i), .busy_o(busy_o),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .sdata_i(sdata_i), .shdn_n_o(shdn_n_o),
    .result_o(result_o), .valid_o(valid_o), .timeout_o(timeout_o)
  );

  function automatic int exp_gap(input int a, input int b);
    if (a >= b) return a;
    return b;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Converter model and line monitor, on the falling clock edge.
  logic [RES-1:0] m_code = '0;
  int  m_conv  = 10;
  bit  m_noeoc = 1'b0;
  int  mphase = 0, mcnt = 0, bidx = 0;
  int  hi_len = 0, last_hi = 0, lo_len = 0, ph_len = 1, min_ph = 1000000;
  int  rises = 0, pre_rises = 0, cs_falls = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b0;

  initial sdata_i = 1'b0;

  always @(negedge clk) begin
    if (prev_cs && !cs_n_o) begin
      cs_falls++;
      last_hi = hi_len;
      hi_len = 0;
      lo_len = 0;
      rises = 0;
      pre_rises = 0;
      min_ph = 1000000;
    end
    if (cs_n_o) hi_len++;
    else lo_len++;
    if (sclk_o != prev_sclk) begin
      if (!cs_n_o && ph_len < min_ph) min_ph = ph_len;
      ph_len = 1;
    end else begin
      ph_len++;
    end
    if (sclk_o && !prev_sclk) begin
      rises++;
      if (mphase == 0) pre_rises++;
    end
    if (cs_n_o) begin
      sdata_i = 1'b0;
      mphase = 0;
      mcnt = 0;
    end else if (mphase == 0) begin
      if (!m_noeoc && mcnt == m_conv) begin
        sdata_i = 1'b1;
        mphase = 1;
        bidx = RES;
      end else begin
        mcnt++;
      end
    end else if (!sclk_o && prev_sclk) begin
      if (bidx > 0) begin
        bidx--;
        sdata_i = m_code[bidx];
      end else begin
        sdata_i = 1'b0;
      end
    end
    prev_cs = cs_n_o;
    prev_sclk = sclk_o;
  end

  logic [RES-1:0] prev_result = '0;

  task automatic run_frame(input logic [RES-1:0] code, input int conv,
                           input bit no_eoc, input bit extra_start);
    int falls0;
    int g;
    m_code  = code;
    m_conv  = conv;
    m_noeoc = no_eoc;
    g = 0;
    while (busy_o && g < 5000) begin
      @(negedge clk);
      g++;
    end
    falls0 = cs_falls;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      start_i = (extra_start && (n == 300 || n == 1200)) ? 1'b1 : 1'b0;
      if (valid_o || timeout_o) break;
    end
    start_i = 1'b0;
    if (no_eoc) begin
      chk(timeout_o == 1'b1, "R7", "timeout pulse", int'(timeout_o), 1);
      chk(valid_o == 1'b0, "R7", "no valid on timeout", int'(valid_o), 0);
      chk(lo_len == TMO, "R7", "chip select low time", lo_len, TMO);
      chk(rises == 0, "R7", "no clock edges on timeout", rises, 0);
      chk(result_o == prev_result, "R7", "result kept", int'(result_o), int'(prev_result));
    end else begin
      chk(valid_o == 1'b1, "R6", "valid pulse", int'(valid_o), 1);
      chk(cs_n_o == 1'b1, "R6", "chip select high with valid", int'(cs_n_o), 1);
      chk(result_o == code, "R5", "result code", int'(result_o), int'(code));
      chk(rises == RES + 1, "R4", "rising edges per frame", rises, RES + 1);
      chk(min_ph >= HALF, "R4", "shortest clock phase", min_ph, HALF);
      chk(pre_rises == 0, "R3", "edges before end of conversion", pre_rises, 0);
      chk(timeout_o == 1'b0, "R7", "no timeout on good frame", int'(timeout_o), 0);
    end
    chk(last_hi >= exp_gap(CSH, ACQ), "R8", "chip select high gap", last_hi, exp_gap(CSH, ACQ));
    chk(cs_falls == falls0 + 1, "R2", "one frame per accepted start", cs_falls, falls0 + 1);
    @(negedge clk);
    chk(valid_o == 1'b0, "R6", "valid is single cycle", int'(valid_o), 0);
    if (!no_eoc) prev_result = code;
    chk(result_o == prev_result, "R6", "result holds", int'(result_o), int'(prev_result));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_up();
  end

  initial begin
    int f0;
    void'($urandom(32'd20240611));
    rst = 1'b1;
    start_i = 1'b0;
    sleep_i = 1'b0;
    repeat (5) @(negedge clk);
    chk(cs_n_o == 1'b1, "R1", "reset chip select", int'(cs_n_o), 1);
    chk(sclk_o == 1'b0, "R1", "reset serial clock", int'(sclk_o), 0);
    chk(valid_o == 1'b0 && timeout_o == 1'b0, "R1", "reset pulses",
        int'(valid_o) + int'(timeout_o), 0);
    chk(result_o == '0, "R1", "reset result", int'(result_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy_o == 1'b1, "R1", "busy during gap after reset", int'(busy_o), 1);
    f0 = cs_falls;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (10) @(negedge clk);
    chk(cs_falls == f0, "R2", "start during reset gap ignored", cs_falls, f0);

    // Directed codes and delays.
    run_frame(10'h000, 5, 1'b0, 1'b0);
    run_frame(10'h3FF, 1800, 1'b0, 1'b0);
    run_frame(10'h200, 40, 1'b0, 1'b0);
    run_frame(10'h155, 600, 1'b0, 1'b0);
    run_frame(10'h2AA, 1, 1'b0, 1'b0);
    run_frame(10'h001, 1500, 1'b0, 1'b0);

    // Timeout, then result must be unchanged.
    run_frame(10'h0F0, 0, 1'b1, 1'b0);

    // Start requests while busy.
    run_frame(10'h13C, 200, 1'b0, 1'b1);
    f0 = cs_falls;
    repeat (exp_gap(CSH, ACQ) + 100) @(negedge clk);
    chk(cs_falls == f0, "R2", "no frame from ignored start", cs_falls, f0);

    // Shutdown.
    sleep_i = 1'b1;
    repeat (2) @(negedge clk);
    chk(shdn_n_o == 1'b0, "R9", "shutdown driven", int'(shdn_n_o), 0);
    f0 = cs_falls;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (600) @(negedge clk);
    chk(cs_falls == f0, "R9", "no start under shutdown", cs_falls, f0);
    chk(cs_n_o == 1'b1, "R9", "chip select high under shutdown", int'(cs_n_o), 1);
    sleep_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(shdn_n_o == 1'b1, "R9", "shutdown released", int'(shdn_n_o), 1);
    run_frame(10'h2C7, 300, 1'b0, 1'b0);

    // Random codes and conversion delays.
    for (int i = 0; i < 16; i++) begin
      logic [RES-1:0] c;
      int d;
      c = RES'($urandom_range(0, (1 << RES) - 1));
      d = int'($urandom_range(1, 1800));
      run_frame(c, d, 1'b0, 1'b0);
    end

    finish_up();
  end
endmodule